// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block is the per-port store of pad control settings for a group of general-purpose pins. Software reaches it through a plain register port (address, write enable, write data, combinational read data). Each register holds one bit per pin. The registers cover the following settings:

- direction
- hand-over to an alternate (hardware) function
- open-drain mode
- digital enable
- weak pull-up and weak pull-down
- three drive-strength selects (2, 4 and 8 mA)
- slew-rate limiting

From the stored bits the block derives per-pin control lines for the pad models and for the core-side data path.

Some settings cannot be active at the same time, and the bank enforces this in hardware on every write. A 1 written into one register of a mutually exclusive group clears the same pin in the sibling registers within the same clock edge. The groups are the two pull registers and the three drive-strength registers. A pin whose digital enable is off neither drives its pad nor passes pad input to the core. Slew limiting reaches the pad only while the 8 mA drive is selected.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: Out of reset, these registers read all zeros: direction (address 0), alternate select (1), open-drain (2), pull-up (4), pull-down (5), 4 mA drive (7), 8 mA drive (8) and slew (9). The 2 mA drive register (6) reads all ones. Digital enable (3) reads the DBG_PINS parameter.
- R2: A write to a mapped address 0 to 9 stores wdata, and the value is visible on rdata at that address from the next cycle. A write to an address from 10 to 15 changes no register, and a read of those addresses returns 0.
- R3: Writing the pull-up register (address 4) clears, in the same edge, every pull-down bit whose pin gets a 1 in wdata.
- R4: Writing the pull-down register (address 5) clears, in the same edge, every pull-up bit whose pin gets a 1 in wdata.
- R5: Writing any one of the drive registers (6, 7 or 8) clears, in the same edge, that pin's bit in the other two drive registers for every pin that gets a 1 in wdata.
- R6: A 0 bit written to any register of an exclusive group leaves that pin unchanged in the sibling registers.
- R7: pad_slew for a pin equals its slew bit AND its 8 mA drive bit.
- R8: pad_oe for a pin is 1 only when digital enable is 1, direction is 1 and alternate select is 0. pad_alt is digital enable AND alternate select.
- R9: pad_od is digital enable AND the open-drain bit. The pin then acts as an open-drain output when its direction bit is 1 (pad_oe high) and as an open-drain input when it is 0.
- R10: A pin with digital enable 0 has pad_oe, pad_alt, pad_od and core_in all 0, whatever pad_in and the other registers hold.
- R11: Every register reads back its stored value, including bits cleared as a side effect of writes to a sibling.
- R12: pad_pu, pad_pd, pad_drv2, pad_drv4 and pad_drv8 follow the stored register bits directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register address |
| wdata | input | N_PINS | Write data, one bit per pin |
| rdata | output | N_PINS | Stored value at addr (0 when unmapped) |
| pad_in | input | N_PINS | Level sensed at each pad |
| core_in | output | N_PINS | Pad level passed to the core, gated by digital enable |
| pad_oe | output | N_PINS | Software output driver enable |
| pad_alt | output | N_PINS | Pad handed to the alternate function |
| pad_od | output | N_PINS | Open-drain mode |
| pad_pu | output | N_PINS | Weak pull-up enable |
| pad_pd | output | N_PINS | Weak pull-down enable |
| pad_drv2 | output | N_PINS | 2 mA drive select |
| pad_drv4 | output | N_PINS | 4 mA drive select |
| pad_drv8 | output | N_PINS | 8 mA drive select |
| pad_slew | output | N_PINS | Slew limiting active |

## Verification
The bench targets the sibling-clearing rules with overlapping bit patterns, where only some pins collide. A design that cleared whole sibling registers, or cleared on 0 bits, would show wrong pull or drive bits on rdata and on the pad lines. Writes of all zeros to drive registers follow, and a bank that let them ripple into siblings would lose the remaining drive select. Digital enable is switched off while pad_in toggles and direction and open-drain are set. A leaky gate would show up on core_in or pad_oe. Writes to unmapped addresses follow each pass, so aliasing decode would corrupt a real register. Slew is set with and without the 8 mA select, which exposes an ungated slew line.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 10;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR = 4'd0,
    RA_ALT = 4'd1,
    RA_ODN = 4'd2,
    RA_DEN = 4'd3,
    RA_PUP = 4'd4,
    RA_PDN = 4'd5,
    RA_DR2 = 4'd6,
    RA_DR4 = 4'd7,
    RA_DR8 = 4'd8,
    RA_SLW = 4'd9
  } reg_addr_e;

  // indices inside the plain register bank
  localparam int PL_DIR = 0;
  localparam int PL_ALT = 1;
  localparam int PL_ODN = 2;
  localparam int PL_DEN = 3;
  localparam int PL_SLW = 4;
  localparam int PL_CNT = 5;
endpackage

// File: rtl/padcfg_plain_bank.sv
module padcfg_plain_bank #(
  parameter int                 N   = 8,
  parameter int                 K   = 5,
  parameter logic [K*N-1:0]     RST = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [K-1:0]          wr_hit,
  input  logic [N-1:0]          wdata,
  output logic [K-1:0][N-1:0]   q
);
  for (genvar k = 0; k < K; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[k] <= RST[k*N +: N];
      else if (wr_hit[k]) q[k] <= wdata;
    end
  end

  // R2: a write stores exactly the written word
  for (genvar k = 0; k < K; k++) begin : g_chk
    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (q[k] == $past(wdata)));
  end
endmodule

// File: rtl/padcfg_excl_group.sv
module padcfg_excl_group #(
  parameter int                 N   = 8,
  parameter int                 G   = 2,
  parameter logic [G*N-1:0]     RST = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [G-1:0]          wr_hit,
  input  logic [N-1:0]          wdata,
  output logic [G-1:0][N-1:0]   q
);
  function automatic logic [N-1:0] knock_out(input logic [N-1:0] held,
                                             input logic [N-1:0] set_bits);
    return held & ~set_bits;
  endfunction

  for (genvar g = 0; g < G; g++) begin : g_mem
    localparam logic [G-1:0] SELF = G'(1) << g;
    logic sibling_written;
    logic [N-1:0] others_or;
    assign sibling_written = |(wr_hit & ~SELF);

    always_comb begin
      others_or = '0;
      for (int h = 0; h < G; h++)
        if (h != g) others_or = others_or | q[h];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q[g] <= RST[g*N +: N];
      else if (wr_hit[g])       q[g] <= wdata;
      else if (sibling_written) q[g] <= knock_out(q[g], wdata);
    end

    // R3 R4 R5: pins written with 1 are cleared in every sibling
    assert_sibling_clear_R3_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> ((others_or & $past(wdata)) == '0));
    // R6: pins written with 0 leave the siblings alone
    assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[g] && wdata == '0) |=> $stable(others_or));
  end
endmodule

// File: rtl/padcfg_pin_ctl.sv
module padcfg_pin_ctl (
  input  logic dir_b,
  input  logic alt_b,
  input  logic odn_b,
  input  logic den_b,
  input  logic drv8_b,
  input  logic slw_b,
  input  logic pad_in_b,
  output logic oe_b,
  output logic alt_own_b,
  output logic od_b,
  output logic slew_b,
  output logic core_in_b
);
  function automatic logic gate(input logic en, input logic v);
    return en & v;
  endfunction

  assign oe_b      = gate(den_b, dir_b & ~alt_b);
  assign alt_own_b = gate(den_b, alt_b);
  assign od_b      = gate(den_b, odn_b);
  assign slew_b    = gate(drv8_b, slw_b);
  assign core_in_b = gate(den_b, pad_in_b);
endmodule

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank
  import gpio_padcfg_pkg::*;
#(
  parameter int                N_PINS   = 8,
  parameter logic [N_PINS-1:0] DBG_PINS = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [N_PINS-1:0]    wdata,
  output logic [N_PINS-1:0]    rdata,
  input  logic [N_PINS-1:0]    pad_in,
  output logic [N_PINS-1:0]    core_in,
  output logic [N_PINS-1:0]    pad_oe,
  output logic [N_PINS-1:0]    pad_alt,
  output logic [N_PINS-1:0]    pad_od,
  output logic [N_PINS-1:0]    pad_pu,
  output logic [N_PINS-1:0]    pad_pd,
  output logic [N_PINS-1:0]    pad_drv2,
  output logic [N_PINS-1:0]    pad_drv4,
  output logic [N_PINS-1:0]    pad_drv8,
  output logic [N_PINS-1:0]    pad_slew
);
  localparam logic [N_PINS-1:0]          ZW  = '0;
  localparam logic [N_PINS-1:0]          OW  = '1;
  localparam logic [PL_CNT*N_PINS-1:0]   PL_RST = {ZW, DBG_PINS, ZW, ZW, ZW};
  localparam logic [2*N_PINS-1:0]        PULL_RST = {ZW, ZW};
  localparam logic [3*N_PINS-1:0]        DRV_RST  = {ZW, ZW, OW};

  logic [NUM_REGS-1:0]            wr_hit;
  logic [PL_CNT-1:0]              plain_hit;
  logic [1:0]                     pull_hit;
  logic [2:0]                     drv_hit;
  logic [PL_CNT-1:0][N_PINS-1:0]  plain_q;
  logic [1:0][N_PINS-1:0]         pull_q;
  logic [2:0][N_PINS-1:0]         drv_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign wr_hit[r] = wr_en && (addr == ADDR_W'(r));
  end

  assign plain_hit = {wr_hit[RA_SLW], wr_hit[RA_DEN], wr_hit[RA_ODN],
                      wr_hit[RA_ALT], wr_hit[RA_DIR]};
  assign pull_hit  = {wr_hit[RA_PDN], wr_hit[RA_PUP]};
  assign drv_hit   = {wr_hit[RA_DR8], wr_hit[RA_DR4], wr_hit[RA_DR2]};

  padcfg_plain_bank #(.N(N_PINS), .K(PL_CNT), .RST(PL_RST)) u_plain (
    .clk(clk), .rst_n(rst_n), .wr_hit(plain_hit), .wdata(wdata), .q(plain_q));

  padcfg_excl_group #(.N(N_PINS), .G(2), .RST(PULL_RST)) u_pull (
    .clk(clk), .rst_n(rst_n), .wr_hit(pull_hit), .wdata(wdata), .q(pull_q));

  padcfg_excl_group #(.N(N_PINS), .G(3), .RST(DRV_RST)) u_drive (
    .clk(clk), .rst_n(rst_n), .wr_hit(drv_hit), .wdata(wdata), .q(drv_q));

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    padcfg_pin_ctl u_pin (
      .dir_b    (plain_q[PL_DIR][p]),
      .alt_b    (plain_q[PL_ALT][p]),
      .odn_b    (plain_q[PL_ODN][p]),
      .den_b    (plain_q[PL_DEN][p]),
      .drv8_b   (drv_q[2][p]),
      .slw_b    (plain_q[PL_SLW][p]),
      .pad_in_b (pad_in[p]),
      .oe_b     (pad_oe[p]),
      .alt_own_b(pad_alt[p]),
      .od_b     (pad_od[p]),
      .slew_b   (pad_slew[p]),
      .core_in_b(core_in[p]));
  end

  assign pad_pu   = pull_q[0];
  assign pad_pd   = pull_q[1];
  assign pad_drv2 = drv_q[0];
  assign pad_drv4 = drv_q[1];
  assign pad_drv8 = drv_q[2];

  always_comb begin
    case (addr)
      RA_DIR:  rdata = plain_q[PL_DIR];
      RA_ALT:  rdata = plain_q[PL_ALT];
      RA_ODN:  rdata = plain_q[PL_ODN];
      RA_DEN:  rdata = plain_q[PL_DEN];
      RA_PUP:  rdata = pull_q[0];
      RA_PDN:  rdata = pull_q[1];
      RA_DR2:  rdata = drv_q[0];
      RA_DR4:  rdata = drv_q[1];
      RA_DR8:  rdata = drv_q[2];
      RA_SLW:  rdata = plain_q[PL_SLW];
      default: rdata = '0;
    endcase
  end

  // observation wires for the checks below
  logic [N_PINS-1:0] den_off;
  logic [N_PINS-1:0] gated_leak;
  logic [N_PINS-1:0] pull_clash;
  assign den_off    = ~plain_q[PL_DEN];
  assign gated_leak = den_off & (pad_oe | pad_alt | pad_od | core_in);
  assign pull_clash = pull_q[0] & pull_q[1];

  assert_den_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gated_leak == '0);
  assert_slew_needs_8ma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_slew & ~pad_drv8) == '0);
  assert_alt_blocks_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_alt) == '0);
  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hit == '0) |=> ($stable(plain_q) && $stable(pull_q) && $stable(drv_q)));
  assert_pull_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[RA_PUP] |=> ((pull_clash & $past(wdata)) == '0));
endmodule

// File: tb/gpio_padcfg_bank_bench.sv
module gpio_padcfg_bank_bench;
  localparam int N = 8;
  localparam logic [N-1:0] DBG = 8'hC0;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] wdata = '0, pad_in = '0;
  logic [N-1:0] rdata, core_in, pad_oe, pad_alt, pad_od, pad_pu, pad_pd;
  logic [N-1:0] pad_drv2, pad_drv4, pad_drv8, pad_slew;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_padcfg_bank #(.N_PINS(N), .DBG_PINS(DBG)) u_gpio_padcfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .core_in(core_in), .pad_oe(pad_oe),
    .pad_alt(pad_alt), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_drv2(pad_drv2), .pad_drv4(pad_drv4), .pad_drv8(pad_drv8),
    .pad_slew(pad_slew));

  // behavioural reference: a word per address
  logic [N-1:0] m [16];

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = '0;
    m[6] = '1;
    m[3] = DBG;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (wr_en) begin
      if (addr <= 4'd9) m[addr] = wdata;
      if (addr == 4'd4) m[5] = m[5] & ~wdata;
      if (addr == 4'd5) m[4] = m[4] & ~wdata;
      if (addr == 4'd6) begin m[7] = m[7] & ~wdata; m[8] = m[8] & ~wdata; end
      if (addr == 4'd7) begin m[6] = m[6] & ~wdata; m[8] = m[8] & ~wdata; end
      if (addr == 4'd8) begin m[6] = m[6] & ~wdata; m[7] = m[7] & ~wdata; end
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata, (addr <= 4'd9) ? m[addr] : '0, "R2/R11 rdata");
      chk(pad_oe,  m[3] & m[0] & ~m[1], "R8 pad_oe");
      chk(pad_alt, m[3] & m[1], "R8 pad_alt");
      chk(pad_od,  m[3] & m[2], "R9 pad_od");
      chk(core_in, m[3] & pad_in, "R10 core_in");
      chk(pad_slew, m[9] & m[8], "R7 pad_slew");
      chk(pad_pu, m[4], "R3 pad_pu");
      chk(pad_pd, m[5], "R4 pad_pd");
      chk(pad_drv2, m[6], "R5 pad_drv2");
      chk(pad_drv4, m[7], "R5 pad_drv4");
      chk(pad_drv8, m[8], "R12 pad_drv8");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [N-1:0] exp, input string tag);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk); #1;
    chk(rdata, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset contents
    for (int a = 0; a < 10; a++)
      rd_expect(4'(a), (a == 6) ? 8'hFF : (a == 3) ? DBG : 8'h00, "R1 reset value");
    // R8 R9 R10 basic configuration
    wr(4'd3, 8'hFF); wr(4'd0, 8'h0F); wr(4'd1, 8'h30); wr(4'd2, 8'h55);
    pad_in = 8'hA5;
    rd_expect(4'd2, 8'h55, "R9 open-drain readback");
    // R3 R4 R11 pull exclusion
    wr(4'd4, 8'hF0);
    wr(4'd5, 8'h3C);
    rd_expect(4'd4, 8'hC0, "R4 pull-up cleared by pull-down write");
    wr(4'd4, 8'h0C);
    rd_expect(4'd5, 8'h30, "R3 pull-down cleared by pull-up write");
    wr(4'd4, 8'h00);
    rd_expect(4'd5, 8'h30, "R6 zero pull-up write keeps pull-down");
    // R5 R6 R7 drive exclusion and slew
    wr(4'd8, 8'h0F);
    rd_expect(4'd6, 8'hF0, "R5 2mA cleared by 8mA write");
    wr(4'd7, 8'h03);
    rd_expect(4'd8, 8'h0C, "R5 8mA cleared by 4mA write");
    wr(4'd9, 8'hFF);
    rd_expect(4'd9, 8'hFF, "R7 slew stored");
    wr(4'd6, 8'h00);
    rd_expect(4'd7, 8'h03, "R6 zero 2mA write keeps 4mA");
    rd_expect(4'd8, 8'h0C, "R6 zero 2mA write keeps 8mA");
    // R10 digital enable off
    wr(4'd3, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2 pad_in = ~pad_in;
    end
    // R2 unmapped writes and reads
    wr(4'd12, 8'hFF); wr(4'd15, 8'h5A);
    rd_expect(4'd12, 8'h00, "R2 unmapped reads zero");
    rd_expect(4'd0, 8'h0F, "R2 direction untouched by unmapped write");
    // random traffic, compared every cycle by the monitor
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #2;
      wr_en  = ($urandom % 3) != 0;
      addr   = 4'($urandom % 12);
      wdata  = 8'($urandom);
      pad_in = 8'($urandom);
    end
    @(posedge clk); #2 wr_en = 0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule